// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives a multi-function I/O device a two-address configuration window. Software writes a register number to the index address (offset 0). It then reads or writes that register through the data address (offset 1). The window stays closed until a key byte is written to the index address, and a second byte closes it again. While the window is closed, stray bus traffic cannot disturb the settings.

A device-select register picks one of several per-device register banks. Every later access to a per-device index goes to that bank. Each bank holds the settings of one peripheral function: an I/O base address, an interrupt line, a DMA channel, two mode bytes and an enable bit. Chosen banks also hold a second interrupt line. The settings of every bank are driven out continuously, so the peripherals can use them directly. A global index returns a fixed identification byte, which software checks before it programs the banks.

Top module: `cfgp_keyport`

## Requirements
- R1: While locked, an index-address write of 0x55 unlocks the port; an index-address write of any other byte leaves it locked and changes nothing.
- R2: While unlocked, an index-address write of 0xAA locks the port. Any other byte written there, 0x55 included, becomes the current index.
- R3: While locked, data-address writes are ignored, and a read of either address returns 0xFF.
- R4: Index 0x20 reads 0x40 and ignores writes.
- R5: Index 0x07 holds the device number, which reads back as the full byte. Per-device indices reach the bank with that number. A device number of NUM_DEV or above reaches no bank: its reads return 0x00 and its writes are ignored.
- R6: In a bank, index 0x60 is the high byte and index 0x61 the low byte of the 16-bit base output. Index 0x70 drives the interrupt output and index 0x74 the DMA output. All four read back the value written.
- R7: Index 0x30 is the activate register. Bit 0 drives the bank's enable output, and the other bits read as 0.
- R8: Indices 0xF0 and 0xF1 are the bank's two mode bytes, driven on the mode outputs. For example, writing 0x02 at 0xF1 of bank 3 shows 0x02 on that bank's second mode output.
- R9: Index 0x72 (second interrupt) exists only in the banks flagged in IRQ2_BANKS, which by default is bank 7 only. In every other bank it reads 0x00 and ignores writes.
- R10: Any other index reads 0x00, and writes to it are ignored.
- R11: After reset the port is locked, the index and the device number are 0, and every bank register and output is zero.
- R12: While unlocked, a read of the index address returns the current index. When no read strobe is given, read data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_addr | input | 1 | 0 = index address, 1 = data address |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| dev_active | output | NUM_DEV | Per-bank enable |
| dev_base | output | 16*NUM_DEV | Per-bank I/O base |
| dev_irq | output | 8*NUM_DEV | Per-bank interrupt line |
| dev_irq2 | output | 8*NUM_DEV | Per-bank second interrupt line |
| dev_dma | output | 8*NUM_DEV | Per-bank DMA channel |
| dev_mode0 | output | 8*NUM_DEV | Per-bank mode byte at 0xF0 |
| dev_mode1 | output | 8*NUM_DEV | Per-bank mode byte at 0xF1 |

## Verification
The assertions assume that a strobe carries a read or a write, never both, and that the bus inputs are stable across each clock edge. They also assume that bank outputs change only through data-address writes. The bench drives every input on the falling edge. It raises at most one of the read and write qualifiers per access, and it only writes through the bus. Random index choices mix the implemented indices with arbitrary bytes, so lock and unlock keys also occur by chance.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int DW = 8;
   localparam logic [DW-1:0] IX_LDN     = 8'h07;
   localparam logic [DW-1:0] IX_ID      = 8'h20;
   localparam logic [DW-1:0] IX_ACT     = 8'h30;
   localparam logic [DW-1:0] IX_BASE_HI = 8'h60;
   localparam logic [DW-1:0] IX_BASE_LO = 8'h61;
   localparam logic [DW-1:0] IX_IRQ     = 8'h70;
   localparam logic [DW-1:0] IX_IRQ2    = 8'h72;
   localparam logic [DW-1:0] IX_DMA     = 8'h74;
   localparam logic [DW-1:0] IX_MODE0   = 8'hF0;
   localparam logic [DW-1:0] IX_MODE1   = 8'hF1;
   localparam logic [DW-1:0] LOCKED_RD  = 8'hFF;
endpackage

// File: rtl/cfgp_lock.sv
module cfgp_lock
   import cfgp_pkg::*;
#(
   parameter logic [DW-1:0] KEY_OPEN  = 8'h55,
   parameter logic [DW-1:0] KEY_CLOSE = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idx_wr,
   input  logic [DW-1:0] wdata,
   output logic          unlocked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         unlocked <= 1'b0;
      else if (idx_wr) begin
         if (!unlocked && wdata == KEY_OPEN)
            unlocked <= 1'b1;
         else if (unlocked && wdata == KEY_CLOSE)
            unlocked <= 1'b0;
      end
   end
endmodule

// File: rtl/cfgp_bank.sv
module cfgp_bank
   import cfgp_pkg::*;
#(
   parameter bit HAS_IRQ2 = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          active,
   output logic [15:0]   base,
   output logic [DW-1:0] irq,
   output logic [DW-1:0] irq2,
   output logic [DW-1:0] dma,
   output logic [DW-1:0] mode0,
   output logic [DW-1:0] mode1
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         base   <= '0;
         irq    <= '0;
         dma    <= '0;
         mode0  <= '0;
         mode1  <= '0;
      end else if (we) begin
         case (idx)
            IX_ACT:     active      <= wdata[0];
            IX_BASE_HI: base[15:8]  <= wdata;
            IX_BASE_LO: base[7:0]   <= wdata;
            IX_IRQ:     irq         <= wdata;
            IX_DMA:     dma         <= wdata;
            IX_MODE0:   mode0       <= wdata;
            IX_MODE1:   mode1       <= wdata;
            default: ;
         endcase
      end
   end

   generate
      if (HAS_IRQ2) begin : g_irq2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq2 <= '0;
            else if (we && idx == IX_IRQ2)
               irq2 <= wdata;
         end
      end else begin : g_no_irq2
         assign irq2 = '0;
      end
   endgenerate

   always_comb begin
      case (idx)
         IX_ACT:     rdata = {7'b0, active};
         IX_BASE_HI: rdata = base[15:8];
         IX_BASE_LO: rdata = base[7:0];
         IX_IRQ:     rdata = irq;
         IX_IRQ2:    rdata = irq2;
         IX_DMA:     rdata = dma;
         IX_MODE0:   rdata = mode0;
         IX_MODE1:   rdata = mode1;
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/cfgp_keyport.sv
module cfgp_keyport
   import cfgp_pkg::*;
#(
   parameter int              NUM_DEV    = 8,
   parameter logic [7:0]      DEV_ID     = 8'h40,
   parameter logic [7:0]      KEY_OPEN   = 8'h55,
   parameter logic [7:0]      KEY_CLOSE  = 8'hAA,
   parameter logic [255:0]    IRQ2_BANKS = 256'h80
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_addr,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [7:0]              bus_wdata,
   output logic [7:0]              bus_rdata,
   output logic [NUM_DEV-1:0]      dev_active,
   output logic [16*NUM_DEV-1:0]   dev_base,
   output logic [8*NUM_DEV-1:0]    dev_irq,
   output logic [8*NUM_DEV-1:0]    dev_irq2,
   output logic [8*NUM_DEV-1:0]    dev_dma,
   output logic [8*NUM_DEV-1:0]    dev_mode0,
   output logic [8*NUM_DEV-1:0]    dev_mode1
);
   localparam int BW = 16;

   initial begin
      if (NUM_DEV < 1 || NUM_DEV > 256)
         $error("cfgp_keyport: NUM_DEV must lie in 1..256");
      if (KEY_OPEN == KEY_CLOSE)
         $error("cfgp_keyport: open and close keys must differ");
   end

   logic          unlocked;
   logic [DW-1:0] index_q;
   logic [DW-1:0] ldn_q;
   logic          idx_wr, dat_wr;
   logic [DW-1:0] bank_rd [NUM_DEV];
   logic [DW-1:0] sel_rd;
   logic [DW-1:0] rd_val;

   assign idx_wr = bus_sel & bus_wr & ~bus_addr;
   assign dat_wr = bus_sel & bus_wr &  bus_addr;

   cfgp_lock #(.KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) i_lock (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(bus_wdata),
      .unlocked(unlocked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         ldn_q   <= '0;
      end else begin
         if (idx_wr && unlocked && bus_wdata != KEY_CLOSE)
            index_q <= bus_wdata;
         if (dat_wr && unlocked && index_q == IX_LDN)
            ldn_q <= bus_wdata;
      end
   end

   generate
      for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
         logic we;
         assign we = dat_wr & unlocked & (ldn_q == 8'(g));
         cfgp_bank #(.HAS_IRQ2(IRQ2_BANKS[g])) i_bank (
            .clk(clk), .rst_n(rst_n), .we(we), .idx(index_q),
            .wdata(bus_wdata), .rdata(bank_rd[g]),
            .active(dev_active[g]),
            .base(dev_base[g*BW +: BW]),
            .irq(dev_irq[g*DW +: DW]),
            .irq2(dev_irq2[g*DW +: DW]),
            .dma(dev_dma[g*DW +: DW]),
            .mode0(dev_mode0[g*DW +: DW]),
            .mode1(dev_mode1[g*DW +: DW])
         );
      end
   endgenerate

   always_comb begin
      sel_rd = '0;
      for (int g = 0; g < NUM_DEV; g++)
         if (ldn_q == 8'(g)) sel_rd = bank_rd[g];
   end

   always_comb begin
      if (!unlocked)
         rd_val = LOCKED_RD;
      else if (!bus_addr)
         rd_val = index_q;
      else if (index_q == IX_LDN)
         rd_val = ldn_q;
      else if (index_q == IX_ID)
         rd_val = DEV_ID;
      else
         rd_val = sel_rd;
   end

   assign bus_rdata = (bus_sel && bus_rd) ? rd_val : '0;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
   parameter int         NUM_DEV   = 8,
   parameter logic [7:0] DEV_ID    = 8'h40,
   parameter logic [7:0] KEY_OPEN  = 8'h55,
   parameter logic [7:0] KEY_CLOSE = 8'hAA
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_addr,
   input logic                  bus_wr,
   input logic                  bus_rd,
   input logic [7:0]            bus_wdata,
   input logic [7:0]            bus_rdata,
   input logic                  unlocked,
   input logic [7:0]            index_q,
   input logic [NUM_DEV-1:0]    dev_active,
   input logic [16*NUM_DEV-1:0] dev_base
);
   logic iw, dw, dr;
   assign iw = bus_sel & bus_wr & ~bus_addr;
   assign dw = bus_sel & bus_wr &  bus_addr;
   assign dr = bus_sel & bus_rd;

   p_key_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && iw && bus_wdata == KEY_OPEN) |=> unlocked);

   p_other_stays_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && iw && bus_wdata != KEY_OPEN) |=> !unlocked);

   p_exit_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && iw && bus_wdata == KEY_CLOSE) |=> !unlocked);

   p_index_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && iw && bus_wdata != KEY_CLOSE) |=> (index_q == $past(bus_wdata)));

   p_locked_reads_ff_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && dr) |-> (bus_rdata == 8'hFF));

   p_locked_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked && dw) |=> ($stable(dev_base) && $stable(dev_active)));

   p_device_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (unlocked && dr && bus_addr && index_q == 8'h20) |-> (bus_rdata == DEV_ID));

   p_idle_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !dr |-> (bus_rdata == 8'h00));
endmodule

bind cfgp_keyport cfgp_checker #(
   .NUM_DEV(NUM_DEV), .DEV_ID(DEV_ID), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)
) i_cfgp_checker (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_addr(bus_addr),
   .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .unlocked(unlocked), .index_q(index_q),
   .dev_active(dev_active), .dev_base(dev_base)
);

// File: tb/test_cfgp_keyport.sv
module test_cfgp_keyport;
   localparam int CLK_P = 10;
   localparam int ND    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel = 0, addr = 0, wr = 0, rd = 0;
   logic [7:0] wdata = 0;
   logic [7:0] rdata;
   logic [ND-1:0]    act;
   logic [16*ND-1:0] base;
   logic [8*ND-1:0]  irq, irq2, dma, m0, m1;

   int checks = 0, errors = 0;
   bit done = 0;

   // bench model
   bit         mlock;
   logic [7:0] midx, mldn;
   logic [7:0] mem [ND][256];

   always #(CLK_P/2) clk = ~clk;

   cfgp_keyport i_cfgp_keyport (
      .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_addr(addr), .bus_wr(wr),
      .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
      .dev_active(act), .dev_base(base), .dev_irq(irq), .dev_irq2(irq2),
      .dev_dma(dma), .dev_mode0(m0), .dev_mode1(m1)
   );

   function automatic bit impl(int b, logic [7:0] ix);
      case (ix)
         8'h30, 8'h60, 8'h61, 8'h70, 8'h74, 8'hF0, 8'hF1: return 1'b1;
         8'h72: return (b == 7);
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [7:0] exp_read(logic a);
      if (mlock) return 8'hFF;
      if (!a) return midx;
      if (midx == 8'h07) return mldn;
      if (midx == 8'h20) return 8'h40;
      if (mldn >= ND) return 8'h00;
      if (!impl(int'(mldn), midx)) return 8'h00;
      return mem[mldn][midx];
   endfunction

   task automatic check(string req, logic [127:0] got, logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic bus_write(logic a, logic [7:0] d);
      @(negedge clk);
      sel = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk);
      sel = 0; wr = 0;
      if (!a) begin
         if (mlock) begin
            if (d == 8'h55) mlock = 0;
         end else if (d == 8'hAA) mlock = 1;
         else midx = d;
      end else if (!mlock) begin
         if (midx == 8'h07) mldn = d;
         else if (mldn < ND && impl(int'(mldn), midx))
            mem[mldn][midx] = (midx == 8'h30) ? {7'b0, d[0]} : d;
      end
   endtask

   task automatic bus_read(logic a, output logic [7:0] r);
      @(negedge clk);
      sel = 1; rd = 1; addr = a;
      #(CLK_P/4);
      r = rdata;
      @(negedge clk);
      sel = 0; rd = 0;
   endtask

   task automatic check_read(string req, logic a);
      logic [7:0] r;
      bus_read(a, r);
      check(req, 128'(r), 128'(exp_read(a)));
   endtask

   task automatic check_outs(string req);
      for (int b = 0; b < ND; b++) begin
         check(req, {act[b], base[b*16 +: 16], irq[b*8 +: 8], irq2[b*8 +: 8],
                     dma[b*8 +: 8], m0[b*8 +: 8], m1[b*8 +: 8]},
                    {mem[b][8'h30][0], mem[b][8'h60], mem[b][8'h61], mem[b][8'h70],
                     mem[b][8'h72], mem[b][8'h74], mem[b][8'hF0], mem[b][8'hF1]});
      end
   endtask

   task automatic set_reg(logic [7:0] ix, logic [7:0] d);
      bus_write(0, ix);
      bus_write(1, d);
   endtask

   initial begin
      logic [7:0] pick [12] = '{8'h07, 8'h20, 8'h30, 8'h60, 8'h61, 8'h70,
                                8'h72, 8'h74, 8'hF0, 8'hF1, 8'h31, 8'h50};
      logic [7:0] r;
      void'($urandom(32'd2024));
      mlock = 1; midx = 0; mldn = 0;
      for (int b = 0; b < ND; b++)
         for (int i = 0; i < 256; i++) mem[b][i] = 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1;

      // R11 reset state
      check_outs("R11");
      check_read("R11/R3", 1);
      check_read("R3", 0);

      // R1 wrong key keeps locked; R3 locked data write ignored
      bus_write(0, 8'h33);
      bus_write(1, 8'h5A);
      check_read("R1", 1);
      check_outs("R3");
      bus_write(0, 8'h55);
      check_read("R1/R12", 0);
      // R2 0x55 while unlocked becomes index
      bus_write(0, 8'h55);
      check_read("R2/R12", 0);

      // R4 id read, write ignored
      set_reg(8'h20, 8'h99);
      check_read("R4", 1);

      // R5..R8 direct programming of two banks
      set_reg(8'h07, 8'h03);
      check_read("R5", 1);
      set_reg(8'h60, 8'h03); set_reg(8'h61, 8'h78);
      set_reg(8'h70, 8'h07); set_reg(8'h74, 8'h02);
      set_reg(8'hF1, 8'h02); set_reg(8'hF0, 8'h11);
      set_reg(8'h30, 8'hFF);
      check_read("R7", 1);
      check_outs("R6/R7/R8");

      // R9 second interrupt only in bank 7
      set_reg(8'h72, 8'h0C);
      check_read("R9", 1);
      set_reg(8'h07, 8'h07);
      set_reg(8'h72, 8'h0C);
      check_read("R9", 1);
      check_outs("R9");

      // R10 unimplemented index
      set_reg(8'h31, 8'h5C);
      check_read("R10", 1);
      // R5 device number beyond the banks
      set_reg(8'h07, 8'h09);
      set_reg(8'h70, 8'h44);
      check_read("R5", 1);
      check_outs("R5");

      // R2 close key relocks, then R3 locked write ignored
      bus_write(0, 8'hAA);
      check_read("R2", 1);
      bus_write(1, 8'h01);
      check_outs("R3");
      bus_write(0, 8'h55);

      // random traffic
      for (int it = 0; it < 600; it++) begin
         int op = $urandom % 16;
         if (op == 0)
            bus_write(0, mlock ? 8'h55 : 8'hAA);
         else if (op < 6)
            bus_write(0, ($urandom % 4 == 0) ? 8'($urandom) : pick[$urandom % 12]);
         else if (op < 11)
            bus_write(1, (midx == 8'h07) ? 8'($urandom % 10) : 8'($urandom));
         else
            check_read("R5/R6/R10", ($urandom % 4) != 0);
         if (it % 50 == 49) check_outs("R6/R8");
      end
      bus_read(1, r);
      check("R12", 128'(rdata), 128'h0);
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            #(CLK_P * 150000);
            errors++;
            $display("FAIL watchdog: got hang expected completion");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule